// File: doc/BRIEF.md
# Double-Buffered Matrix-Vector Job Sequencer

This block drives a matrix-vector array from a shared multi-bank scratchpad. Each job is launched through a small command port that supplies a source base address and stride, a destination base address and stride, a row count and a column count. A job passes through three phases in a fixed order. First, the row-count input elements are gathered from the scratchpad into an input buffer. Second, the array is started and the block waits for its done pulse, which arrives after a fixed latency. Third, the column-count results are written back to the scratchpad. A one-cycle completion event then marks the end of the job.

The input buffer and the output buffer each have two halves. This lets the gather of the next job and the write-back of the previous job run while the array works on the current one. The gather engine and the write-back engine share one scratchpad master port. The compute engine only hands vectors to the array and captures its results. A command is refused through a busy flag when the next input half is still occupied. A refused command is dropped, not queued.

Top module: `mvm_seq`

## Requirements
- R1: Every accepted job runs gather, compute and write-back in that order. Jobs finish in the order they were accepted. `evt_done` pulses for one cycle after the last result word of a job has been granted, and at that point all of its result words are in the scratchpad.
- R2: Gather reads address `src_base + k*src_stride` for k = 0 .. rows-1. Write-back writes word j to `dst_base + j*dst_stride` for j = 0 .. cols-1. No other scratchpad word is written. Read data is returned on `mem_rdata` with `mem_rvalid`, in grant order. Row and column counts range from 1 to the array size.
- R3: `arr_start` is a one-cycle pulse. It is raised only when a filled input half and a free output half both exist and no compute is in progress. The results on `arr_res` are captured on `arr_done`. Computes never overlap.
- R4: While a compute is in progress, the gather of a later job or the write-back of an earlier job can use the scratchpad port.
- R5: A request that is not granted keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which it is granted. Under any grant pattern, each job issues exactly rows reads and cols writes.
- R6: On `arr_vec`, lane i (bits i*DW and up) is zero for every i at or above the job's row count, whatever the buffer half held before.
- R7: `cmd_busy` is high whenever the next input half is not free. A `cmd_go` that arrives while `cmd_busy` is high is ignored: no job, no scratchpad traffic and no event follows from it.
- R8: When no request is outstanding and both engines want the port, the write-back engine gets it. With the grant held high, no read is granted between the first and the last write of a job's write-back.
- R9: During and right after reset, `mem_req`, `cmd_busy`, `arr_start` and `evt_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Job launch strobe |
| cmd_src_base | input | AW | Gather start address |
| cmd_src_stride | input | AW | Gather address step |
| cmd_dst_base | input | AW | Write-back start address |
| cmd_dst_stride | input | AW | Write-back address step |
| cmd_rows | input | clog2(ROWS+1) | Number of input elements |
| cmd_cols | input | clog2(COLS+1) | Number of result elements |
| cmd_busy | output | 1 | Next input half occupied; launch refused |
| mem_req | output | 1 | Scratchpad request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Scratchpad word address |
| mem_wdata | output | RW | Write data |
| mem_gnt | input | 1 | Grant for the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| arr_start | output | 1 | Array start pulse |
| arr_vec | output | ROWS*DW | Input vector, lane i at bits i*DW |
| arr_done | input | 1 | Array done pulse |
| arr_res | input | COLS*RW | Result vector, lane j at bits j*RW |
| evt_done | output | 1 | Job completion event |

## Verification
The case of most interest is two engines wanting the single scratchpad port in the same cycle. This happens when the write-back of a finished job and the gather of a newly accepted job collide. The bench provokes it by issuing a third job at the first negedge where `cmd_busy` falls. That moment is the cycle after the array's done pulse frees an input half, so the new gather starts one cycle after the write-back begins. With the grant held high, any read granted inside an unfinished write-back burst counts as a failure. The same runs are then repeated under a pseudo-random grant, where every job's results are checked word by word.

// File: rtl/mvm_seq_pkg.sv
package mvm_seq_pkg;

  // occupancy of one buffer half
  typedef enum logic [1:0] {
    HALF_FREE = 2'd0,
    HALF_LOAD = 2'd1,
    HALF_FULL = 2'd2
  } half_st_e;

endpackage

// File: rtl/mvm_seq_stride_gen.sv
module mvm_seq_stride_gen #(
  parameter int AW = 32,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt
);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (load) begin
      addr_d = base;
      cnt_d  = '0;
    end else if (step) begin
      addr_d = addr_q + stride;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr = addr_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/mvm_seq_port_arb.sv
module mvm_seq_port_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_want,
  input  logic wr_want,
  input  logic gnt,
  output logic req,
  output logic sel_wr
);

  logic own_q, own_d;
  logic pend_q, pend_d;

  // an ungranted request keeps its owner; otherwise write-back goes first
  always_comb begin
    own_d  = pend_q ? own_q : wr_want;
    req    = own_d ? wr_want : rd_want;
    pend_d = req & ~gnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      own_q  <= own_d;
      pend_q <= pend_d;
    end
  end

  assign sel_wr = own_d;

  a_r5_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (req && sel_wr == $past(sel_wr)));

endmodule

// File: rtl/mvm_seq.sv
module mvm_seq
  import mvm_seq_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  parameter int DW   = 8,
  parameter int RW   = 32,
  parameter int AW   = 32,
  localparam int RCW = $clog2(ROWS + 1),
  localparam int CCW = $clog2(COLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_go,
  input  logic [AW-1:0]        cmd_src_base,
  input  logic [AW-1:0]        cmd_src_stride,
  input  logic [AW-1:0]        cmd_dst_base,
  input  logic [AW-1:0]        cmd_dst_stride,
  input  logic [RCW-1:0]       cmd_rows,
  input  logic [CCW-1:0]       cmd_cols,
  output logic                 cmd_busy,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [RW-1:0]        mem_wdata,
  input  logic                 mem_gnt,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 arr_start,
  output logic [ROWS*DW-1:0]   arr_vec,
  input  logic                 arr_done,
  input  logic [COLS*RW-1:0]   arr_res,
  output logic                 evt_done
);

  localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CIW = (COLS > 1) ? $clog2(COLS) : 1;

  // control state
  half_st_e [1:0] in_st_q, in_st_d, out_st_q, out_st_d;
  logic wp_q, wp_d, fp_q, fp_d, cp_q, cp_d, op_q, op_d, dp_q, dp_d;
  logic fill_act_q, fill_act_d, comp_act_q, comp_act_d, drain_act_q, drain_act_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic arr_start_q, evt_q;

  // job descriptors per input half and per output half
  logic [1:0][AW-1:0]  h_src_q, h_sstr_q, h_dst_q, h_dstr_q;
  logic [1:0][RCW-1:0] h_rows_q;
  logic [1:0][CCW-1:0] h_cols_q;
  logic [1:0][AW-1:0]  o_dst_q, o_dstr_q;
  logic [1:0][CCW-1:0] o_cols_q;

  logic [DW-1:0] ibuf_q [2][ROWS];
  logic [RW-1:0] obuf_q [2][COLS];

  logic accept, fill_load, fill_fin, comp_go, comp_fin, drain_load, drain_fin;
  logic rd_want, wr_want, sel_wr, gnt_rd, gnt_wr;
  logic [AW-1:0]  rd_addr, wr_addr;
  logic [RCW-1:0] rd_cnt;
  logic [CCW-1:0] wr_cnt;

  assign cmd_busy   = (in_st_q[wp_q] != HALF_FREE);
  assign accept     = cmd_go & ~cmd_busy;
  assign fill_load  = ~fill_act_q & (in_st_q[fp_q] == HALF_LOAD);
  assign rd_want    = fill_act_q & (rd_cnt < h_rows_q[fp_q]);
  assign fill_fin   = fill_act_q & (rcnt_q == h_rows_q[fp_q]);
  assign comp_go    = ~comp_act_q & (in_st_q[cp_q] == HALF_FULL) & (out_st_q[op_q] == HALF_FREE);
  assign comp_fin   = comp_act_q & arr_done;
  assign drain_load = ~drain_act_q & (out_st_q[dp_q] == HALF_FULL);
  assign wr_want    = drain_act_q & (wr_cnt < o_cols_q[dp_q]);
  assign drain_fin  = drain_act_q & (wr_cnt == o_cols_q[dp_q]);
  assign gnt_rd     = mem_req & mem_gnt & ~sel_wr;
  assign gnt_wr     = mem_req & mem_gnt & sel_wr;

  mvm_seq_stride_gen #(.AW(AW), .CW(RCW)) u_rd_gen (
    .clk(clk), .rst_n(rst_n), .load(fill_load),
    .base(h_src_q[fp_q]), .stride(h_sstr_q[fp_q]), .step(gnt_rd),
    .addr(rd_addr), .cnt(rd_cnt));

  mvm_seq_stride_gen #(.AW(AW), .CW(CCW)) u_wr_gen (
    .clk(clk), .rst_n(rst_n), .load(drain_load),
    .base(o_dst_q[dp_q]), .stride(o_dstr_q[dp_q]), .step(gnt_wr),
    .addr(wr_addr), .cnt(wr_cnt));

  mvm_seq_port_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rd_want(rd_want), .wr_want(wr_want),
    .gnt(mem_gnt), .req(mem_req), .sel_wr(sel_wr));

  assign mem_we    = sel_wr;
  assign mem_addr  = sel_wr ? wr_addr : rd_addr;
  assign mem_wdata = sel_wr ? obuf_q[dp_q][wr_cnt[CIW-1:0]] : '0;

  // next-state: the three updates of a half's state start from distinct states
  always_comb begin
    in_st_d     = in_st_q;
    out_st_d    = out_st_q;
    wp_d        = wp_q;
    fp_d        = fp_q;
    cp_d        = cp_q;
    op_d        = op_q;
    dp_d        = dp_q;
    fill_act_d  = fill_act_q;
    comp_act_d  = comp_act_q;
    drain_act_d = drain_act_q;
    rcnt_d      = rcnt_q;
    if (accept) begin
      in_st_d[wp_q] = HALF_LOAD;
      wp_d          = ~wp_q;
    end
    if (fill_load) begin
      fill_act_d = 1'b1;
      rcnt_d     = '0;
    end else if (fill_act_q && mem_rvalid) begin
      rcnt_d = rcnt_q + RCW'(1);
    end
    if (fill_fin) begin
      in_st_d[fp_q] = HALF_FULL;
      fp_d          = ~fp_q;
      fill_act_d    = 1'b0;
    end
    if (comp_go) comp_act_d = 1'b1;
    if (comp_fin) begin
      comp_act_d     = 1'b0;
      in_st_d[cp_q]  = HALF_FREE;
      out_st_d[op_q] = HALF_FULL;
      cp_d           = ~cp_q;
      op_d           = ~op_q;
    end
    if (drain_load) drain_act_d = 1'b1;
    if (drain_fin) begin
      drain_act_d    = 1'b0;
      out_st_d[dp_q] = HALF_FREE;
      dp_d           = ~dp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_st_q     <= {HALF_FREE, HALF_FREE};
      out_st_q    <= {HALF_FREE, HALF_FREE};
      wp_q        <= 1'b0;
      fp_q        <= 1'b0;
      cp_q        <= 1'b0;
      op_q        <= 1'b0;
      dp_q        <= 1'b0;
      fill_act_q  <= 1'b0;
      comp_act_q  <= 1'b0;
      drain_act_q <= 1'b0;
      rcnt_q      <= '0;
      arr_start_q <= 1'b0;
      evt_q       <= 1'b0;
    end else begin
      in_st_q     <= in_st_d;
      out_st_q    <= out_st_d;
      wp_q        <= wp_d;
      fp_q        <= fp_d;
      cp_q        <= cp_d;
      op_q        <= op_d;
      dp_q        <= dp_d;
      fill_act_q  <= fill_act_d;
      comp_act_q  <= comp_act_d;
      drain_act_q <= drain_act_d;
      rcnt_q      <= rcnt_d;
      arr_start_q <= comp_go;
      evt_q       <= drain_fin;
    end
  end

  // data storage: enabled, not reset
  always_ff @(posedge clk) begin
    if (accept) begin
      h_src_q[wp_q]  <= cmd_src_base;
      h_sstr_q[wp_q] <= cmd_src_stride;
      h_dst_q[wp_q]  <= cmd_dst_base;
      h_dstr_q[wp_q] <= cmd_dst_stride;
      h_rows_q[wp_q] <= cmd_rows;
      h_cols_q[wp_q] <= cmd_cols;
    end
    if (fill_act_q && mem_rvalid) ibuf_q[fp_q][rcnt_q[RIW-1:0]] <= mem_rdata;
    if (comp_fin) begin
      o_dst_q[op_q]  <= h_dst_q[cp_q];
      o_dstr_q[op_q] <= h_dstr_q[cp_q];
      o_cols_q[op_q] <= h_cols_q[cp_q];
      for (int j = 0; j < COLS; j++) obuf_q[op_q][j] <= arr_res[j*RW +: RW];
    end
  end

  // lanes past the row count are forced to zero
  for (genvar i = 0; i < ROWS; i++) begin : g_lane
    assign arr_vec[i*DW +: DW] = (RCW'(i) < h_rows_q[cp_q]) ? ibuf_q[cp_q][i] : '0;
  end

  assign arr_start = arr_start_q;
  assign evt_done  = evt_q;

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r3_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> (comp_act_q && in_st_q[cp_q] == HALF_FULL && out_st_q[op_q] == HALF_FREE));

  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);

  a_r7_refuse_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_busy) |=> (wp_q == $past(wp_q)));

endmodule

// File: tb/mvm_seq_bench.sv
module mvm_seq_bench;
  localparam int CLK_P = 10;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int DW    = 8;
  localparam int RW    = 32;
  localparam int AW    = 16;
  localparam int LAT   = 130;
  localparam int LIMIT = 100000;
  localparam int RCW   = $clog2(ROWS + 1);
  localparam int CCW   = $clog2(COLS + 1);

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_P/2) clk = ~clk;

  logic cmd_go;
  logic [AW-1:0] cmd_src_base, cmd_src_stride, cmd_dst_base, cmd_dst_stride;
  logic [RCW-1:0] cmd_rows;
  logic [CCW-1:0] cmd_cols;
  logic cmd_busy, mem_req, mem_we, mem_rvalid, arr_start, arr_done, evt_done;
  logic mem_gnt = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [RW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [ROWS*DW-1:0] arr_vec;
  logic [COLS*RW-1:0] arr_res;

  mvm_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RW(RW), .AW(AW)) u_mvm_seq (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_src_base(cmd_src_base),
    .cmd_src_stride(cmd_src_stride), .cmd_dst_base(cmd_dst_base),
    .cmd_dst_stride(cmd_dst_stride), .cmd_rows(cmd_rows), .cmd_cols(cmd_cols),
    .cmd_busy(cmd_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .arr_start(arr_start), .arr_vec(arr_vec),
    .arr_done(arr_done), .arr_res(arr_res), .evt_done(evt_done));

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // scratchpad model: one read-data cycle after the grant
  logic [31:0] mem [0:4095];
  function automatic logic [31:0] init_word(input int a);
    return {8'hC3, 8'(a >> 4), 8'(a), 8'(a * 29 + 7)};
  endfunction

  int wr_grants = 0, rd_grants = 0, rd_in_comp = 0, wr_run = 0, intlv = 0;
  bit stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // job queue in launch order
  int jq_src[32], jq_ss[32], jq_dst[32], jq_ds[32], jq_rows[32], jq_cols[32];
  int jq_n = 0, evt_n = 0;

  // array stand-in
  logic [ROWS*DW-1:0] sv_vec;
  int sv_cnt = 0, overlap_err = 0;
  bit sv_busy = 1'b0;

  function automatic logic [COLS*RW-1:0] mvm(input logic [ROWS*DW-1:0] v);
    logic [COLS*RW-1:0] r;
    for (int j = 0; j < COLS; j++) begin
      logic [RW-1:0] s;
      s = '0;
      for (int i = 0; i < ROWS; i++) s += RW'(v[i*DW +: DW]) * RW'(i * 3 + j + 1);
      r[j*RW +: RW] = s;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      arr_done <= 1'b0;
      sv_busy  <= 1'b0;
    end else begin
      arr_done <= 1'b0;
      if (arr_start) begin
        if (sv_busy) overlap_err++;
        sv_vec  <= arr_vec;
        sv_busy <= 1'b1;
        sv_cnt  <= LAT;
      end else if (sv_busy) begin
        if (sv_cnt == 1) begin
          arr_done <= 1'b1;
          arr_res  <= mvm(sv_vec);
          sv_busy  <= 1'b0;
        end
        sv_cnt <= sv_cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] <= mem_wdata;
        wr_grants++;
        wr_run++;
      end else begin
        mem_rdata  <= mem[mem_addr[11:0]][DW-1:0];
        mem_rvalid <= 1'b1;
        rd_grants++;
        if (sv_busy) rd_in_comp++;
        if (!stall && wr_run > 0 && wr_run < jq_cols[evt_n]) intlv++;
      end
    end
  end

  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt <= stall ? lfsr[0] : 1'b1;
  end

  function automatic logic [31:0] golden(input int k, input int j);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < jq_rows[k]; i++)
      s += 32'(mem[(jq_src[k] + i * jq_ss[k]) & 12'hFFF][7:0]) * 32'(i * 3 + j + 1);
    return s;
  endfunction

  // R1/R2: on each event the oldest open job must be complete and confined
  task automatic check_job(input int k);
    bit ok = 1'b1;
    longint act = 0, exp = 0;
    for (int j = 0; j < jq_cols[k]; j++) begin
      int a = (jq_dst[k] + j * jq_ds[k]) & 12'hFFF;
      if (ok && mem[a] !== golden(k, j)) begin ok = 1'b0; act = mem[a]; exp = golden(k, j); end
      if (ok && jq_ds[k] > 1 && mem[a + 1] !== init_word(a + 1)) begin
        ok = 1'b0; act = mem[a + 1]; exp = init_word(a + 1);
      end
    end
    if (ok) begin
      int a = (jq_dst[k] + jq_cols[k] * jq_ds[k]) & 12'hFFF;
      if (mem[a] !== init_word(a)) begin ok = 1'b0; act = mem[a]; exp = init_word(a); end
    end
    chk(ok, "R1 R2", $sformatf("job %0d results", k), act, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && evt_done) begin
      check_job(evt_n);
      evt_n++;
      wr_run = 0;
    end
  end

  task automatic issue(input int src, input int ss, input int dst, input int ds,
                       input int rows, input int cols);
    while (cmd_busy) @(negedge clk);
    cmd_src_base = AW'(src); cmd_src_stride = AW'(ss);
    cmd_dst_base = AW'(dst); cmd_dst_stride = AW'(ds);
    cmd_rows = RCW'(rows); cmd_cols = CCW'(cols);
    jq_src[jq_n] = src; jq_ss[jq_n] = ss; jq_dst[jq_n] = dst; jq_ds[jq_n] = ds;
    jq_rows[jq_n] = rows; jq_cols[jq_n] = cols; jq_n++;
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_all();
    while (evt_n < jq_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(mem_req == 1'b0, "R9", "mem_req in reset", mem_req, 0);
    chk(cmd_busy == 1'b0, "R9", "cmd_busy in reset", cmd_busy, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(arr_start == 1'b0, "R9", "arr_start after reset", arr_start, 0);
    chk(evt_done == 1'b0, "R9", "evt_done after reset", evt_done, 0);
  endtask

  task automatic t_basic();
    int w0 = wr_grants, r0 = rd_grants;
    issue(12'h000, 1, 12'h800, 2, 8, 8);
    wait_all();
    chk(wr_grants - w0 == 8, "R5", "basic write count", wr_grants - w0, 8);
    chk(rd_grants - r0 == 8, "R5", "basic read count", rd_grants - r0, 8);
  endtask

  // R4 and R8: back-to-back jobs, third launched the moment busy falls
  task automatic t_overlap();
    issue(12'h040, 3, 12'h900, 1, 8, 8);
    issue(12'h100, 1, 12'h980, 1, 8, 5);
    issue(12'h140, 2, 12'hA00, 1, 6, 8);
    wait_all();
    chk(rd_in_comp > 0, "R4", "reads during compute", rd_in_comp, 1);
    chk(overlap_err == 0, "R3", "overlapping computes", overlap_err, 0);
    chk(intlv == 0, "R8", "reads inside write-back burst", intlv, 0);
  endtask

  task automatic t_lanes();
    bit ok = 1'b1;
    issue(12'h200, 1, 12'hA80, 1, 8, 8);
    issue(12'h210, 1, 12'hB00, 1, 8, 8);
    issue(12'h220, 1, 12'hB80, 1, 3, 8);
    wait_all();
    for (int i = 3; i < ROWS; i++) if (sv_vec[i*DW +: DW] != '0) ok = 1'b0;
    chk(ok, "R6", "upper lanes zero", longint'(sv_vec[ROWS*DW-1:3*DW]), 0);
  endtask

  task automatic t_busy();
    bit ok = 1'b1;
    int e0;
    issue(12'h300, 1, 12'hC80, 1, 8, 8);
    issue(12'h310, 1, 12'hD00, 1, 8, 8);
    chk(cmd_busy == 1'b1, "R7", "busy with both halves taken", cmd_busy, 1);
    cmd_src_base = AW'(12'h320); cmd_src_stride = 1;
    cmd_dst_base = AW'(12'hC00); cmd_dst_stride = 1;
    cmd_rows = RCW'(8); cmd_cols = CCW'(8);
    cmd_go = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (!cmd_busy) ok = 1'b0;
    end
    cmd_go = 1'b0;
    chk(ok, "R7", "busy held during refused launches", ok, 1);
    e0 = evt_n;
    wait_all();
    repeat (300) @(negedge clk);
    chk(evt_n == jq_n, "R7", "no event from refused launch", evt_n, jq_n);
    ok = 1'b1;
    for (int a = 12'hC00; a < 12'hC08; a++) if (mem[a] !== init_word(a)) ok = 1'b0;
    chk(ok, "R7", "refused job region untouched", ok, 1);
    chk(evt_n - e0 == 2, "R1", "events for accepted jobs", evt_n - e0, 2);
  endtask

  task automatic t_stall();
    int w0 = wr_grants, r0 = rd_grants;
    stall = 1'b1;
    issue(12'h380, 2, 12'hD80, 3, 7, 4);
    issue(12'h3A0, 1, 12'hE00, 1, 8, 8);
    issue(12'h3C0, 5, 12'hE80, 2, 5, 6);
    wait_all();
    stall = 1'b0;
    chk(wr_grants - w0 == 18, "R5", "stalled write count", wr_grants - w0, 18);
    chk(rd_grants - r0 == 20, "R5", "stalled read count", rd_grants - r0, 20);
    chk(overlap_err == 0, "R3", "overlapping computes under stall", overlap_err, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = init_word(a);
    rst_n = 1'b0;
    cmd_go = 1'b0;
    cmd_src_base = '0; cmd_src_stride = '0; cmd_dst_base = '0; cmd_dst_stride = '0;
    cmd_rows = '0; cmd_cols = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_overlap();
    t_lanes();
    t_busy();
    t_stall();
    finish_run();
  end

endmodule